// File: doc/BRIEF.md
# Processor clock set divider with bus enable and test bypass

This block takes a fast clock running at processor rate and derives from it the whole set of clocks a board-level distribution tree needs. The fast clock passes straight to a full-rate output. One toggle stage divides it by two and feeds a bank of identical half-rate outputs plus one inverted half-rate output. A second stage divides by two again and gives a quarter-rate feedback tap, which a phase comparator outside this block uses to fix the ratio between reference and outputs.

A bus clock-enable is also produced for logic that runs at half the processor rate. It is retimed on the falling edge of the full-rate clock. As a result it changes half a period away from every rising edge and is steady whenever the processor samples it. A run/test select input replaces the fast clock with the slow reference clock. The whole divider then runs statically from the reference, with no lower frequency limit, which suits board test. An active-low asynchronous reset puts the divider in a known phase.

Top module: `clk_fanout_div`

## Requirements
- R1: With `run_en` high, `x2_clk` follows `fast_clk` level for level.
- R2: Every `q_clk` bit toggles on each rising edge of `x2_clk`, so it runs at exactly half the `x2_clk` frequency. The first rising edge after reset takes it from 0 to 1.
- R3: All `NQ` bits of `q_clk` carry the same value at all times.
- R4: `q_inv` is always the logical inverse of `q_clk`.
- R5: `bus_en` changes only on falling edges of `x2_clk`, where it takes the inverse of `q_clk`. It is therefore 1 across the rising edge that takes `q_clk` from 0 to 1, and 0 across the other rising edges.
- R6: `fb_tap` toggles on exactly those rising edges of `x2_clk` where `q_clk` goes from 0 to 1, giving one quarter of the `x2_clk` frequency. The first rising edge after reset sets it to 1.
- R7: With `run_en` low, `x2_clk` follows `ref_clk`, and the divider of R2, R5 and R6 is clocked by `ref_clk` in place of `fast_clk`.
- R8: While `rst_n` is low, and at once when it falls, `q_clk` is all zeros, `q_inv` is 1, `fb_tap` is 0 and `bus_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low divider reset |
| fast_clk | input | 1 | Processor-rate clock from the oscillator |
| ref_clk | input | 1 | Reference clock, used as the source in test mode |
| run_en | input | 1 | 1 selects fast_clk, 0 selects the ref_clk bypass |
| x2_clk | output | 1 | Full-rate clock output |
| q_clk | output | NQ | Half-rate outputs, all in phase |
| q_inv | output | 1 | Inverted half-rate output |
| bus_en | output | 1 | Half-rate bus clock-enable, retimed on the falling edge |
| fb_tap | output | 1 | Quarter-rate feedback tap |

## Verification
`x2_clk` and `q_inv` are combinational, so they are checked at once. `q_clk` and `fb_tap` settle one register after the rising edge that moves them. `bus_en` settles one register after the falling edge, so the first rising edge after reset still shows its reset value of 0. The bench counts rising edges of the selected source since reset release and derives every expected value from that count. It samples 1 ns after each rising and each falling source edge. It changes `rst_n` and `run_en` only 1.5 ns after a falling edge, so no edge and no sample coincide with a stimulus.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // half-rate stage: toggles on every full-rate rising edge
  function automatic logic half_next(input logic q);
    return ~q;
  endfunction

  // quarter-rate stage: advances only on the edge that raises the half-rate stage
  function automatic logic quarter_next(input logic q, input logic fb);
    return fb ^ ~q;
  endfunction

  // enable level loaded on a full-rate falling edge
  function automatic logic enable_level(input logic q);
    return ~q;
  endfunction

endpackage

// File: rtl/clk_src_sel.sv
module clk_src_sel (
  input  logic fast_clk,
  input  logic ref_clk,
  input  logic run_en,
  output logic src_clk
);
  always_comb begin
    src_clk = run_en ? fast_clk : ref_clk;
  end
endmodule

// File: rtl/div_core.sv
module div_core
  import clkdiv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output logic half_q,
  output logic quarter_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q    <= 1'b0;
      quarter_q <= 1'b0;
    end else begin
      half_q    <= half_next(half_q);
      quarter_q <= quarter_next(half_q, quarter_q);
    end
  end
endmodule

// File: rtl/en_phase.sv
module en_phase
  import clkdiv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic half_q,
  output logic en_q
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= enable_level(half_q);
  end
endmodule

// File: rtl/q_fanout.sv
module q_fanout #(
  parameter int NQ = 3
) (
  input  logic          half_q,
  output logic [NQ-1:0] q_bank,
  output logic          q_neg
);
  for (genvar g = 0; g < NQ; g++) begin : g_leg
    assign q_bank[g] = half_q;
  end
  assign q_neg = ~half_q;
endmodule

// File: rtl/clk_fanout_div.sv
module clk_fanout_div #(
  parameter int NQ = 3
) (
  input  logic          rst_n,
  input  logic          fast_clk,
  input  logic          ref_clk,
  input  logic          run_en,
  output logic          x2_clk,
  output logic [NQ-1:0] q_clk,
  output logic          q_inv,
  output logic          bus_en,
  output logic          fb_tap
);
  logic src_clk;
  logic half_q;
  logic quarter_q;
  logic q_rise_next;

  clk_src_sel u_sel (
    .fast_clk (fast_clk),
    .ref_clk  (ref_clk),
    .run_en   (run_en),
    .src_clk  (src_clk)
  );

  div_core u_div (
    .clk       (src_clk),
    .rst_n     (rst_n),
    .half_q    (half_q),
    .quarter_q (quarter_q)
  );

  en_phase u_en (
    .clk    (src_clk),
    .rst_n  (rst_n),
    .half_q (half_q),
    .en_q   (bus_en)
  );

  q_fanout #(.NQ(NQ)) u_fan (
    .half_q (half_q),
    .q_bank (q_clk),
    .q_neg  (q_inv)
  );

  // the next rising edge will raise the half-rate outputs
  assign q_rise_next = ~half_q;
  assign x2_clk      = src_clk;
  assign fb_tap      = quarter_q;
endmodule

// File: rtl/clk_fanout_div_chk.sv
module clk_fanout_div_chk #(
  parameter int NQ = 3
) (
  input logic          rst_n,
  input logic          x2_clk,
  input logic [NQ-1:0] q_clk,
  input logic          q_inv,
  input logic          bus_en,
  input logic          fb_tap,
  input logic          q_rise_next
);
  logic armed;
  always_ff @(posedge x2_clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R2
  a_r2_half_toggle: assert property (@(posedge x2_clk) disable iff (!rst_n || !armed)
    q_clk[0] != $past(q_clk[0]));

  // R3
  a_r3_bank_equal: assert property (@(posedge x2_clk) disable iff (!rst_n)
    q_clk == {NQ{q_clk[0]}});

  // R4
  a_r4_inverse: assert property (@(negedge x2_clk) disable iff (!rst_n)
    q_inv != q_clk[0]);

  // R5
  a_r5_en_at_sample: assert property (@(posedge x2_clk) disable iff (!rst_n || !armed)
    bus_en == q_rise_next);

  // R6
  a_r6_fb_on_rise: assert property (@(posedge x2_clk) disable iff (!rst_n || !armed)
    (fb_tap != $past(fb_tap)) == ($past(q_clk[0]) == 1'b0));
endmodule

bind clk_fanout_div clk_fanout_div_chk #(.NQ(NQ)) chk_i (
  .rst_n       (rst_n),
  .x2_clk      (x2_clk),
  .q_clk       (q_clk),
  .q_inv       (q_inv),
  .bus_en      (bus_en),
  .fb_tap      (fb_tap),
  .q_rise_next (q_rise_next)
);

// File: tb/clk_fanout_div_tb_top.sv
`timescale 1ns/100ps
module clk_fanout_div_tb_top;
  localparam int NQ = 3;

  logic          rst_n = 1'b0;
  logic          fast_clk = 1'b0;
  logic          ref_clk = 1'b0;
  logic          run_en = 1'b1;
  logic          x2_clk;
  logic [NQ-1:0] q_clk;
  logic          q_inv;
  logic          bus_en;
  logic          fb_tap;

  int total = 0;
  int bad   = 0;
  int n     = 0;
  bit live  = 0;
  bit done  = 0;

  clk_fanout_div #(.NQ(NQ)) dut_i (.*);

  always #2  fast_clk = ~fast_clk;
  always #20 ref_clk  = ~ref_clk;

  wire src = run_en ? fast_clk : ref_clk;

  task automatic chk(input string tag, input logic [NQ-1:0] act, input logic [NQ-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic chk_src(input logic lvl);
    chk(run_en ? "R1 x2 follows fast" : "R7 x2 follows ref", {{(NQ-1){1'b0}}, x2_clk},
        {{(NQ-1){1'b0}}, lvl});
  endtask

  task automatic chk_reset();
    chk("R8 q reset",  q_clk, '0);
    chk("R8 qinv reset", {{(NQ-1){1'b0}}, q_inv}, {{(NQ-1){1'b0}}, 1'b1});
    chk("R8 fb reset", {{(NQ-1){1'b0}}, fb_tap}, '0);
    chk("R8 en reset", {{(NQ-1){1'b0}}, bus_en}, '0);
  endtask

  // model: n = rising source edges since reset release
  always @(posedge src) begin
    if (live) begin
      n++;
      #1;
      begin
        logic q_e, fb_e, en_e;
        q_e  = logic'(n % 2);
        fb_e = logic'(((n + 1) / 2) % 2);
        en_e = (n == 1) ? 1'b0 : q_e;     // R5: loaded on the previous falling edge
        chk_src(1'b1);
        chk(run_en ? "R2 q half rate" : "R7 q from ref", q_clk, {NQ{q_e}});
        chk("R3 bank", q_clk, {NQ{q_clk[0]}});
        chk("R4 inverse", {{(NQ-1){1'b0}}, q_inv}, {{(NQ-1){1'b0}}, ~q_e});
        chk("R6 fb tap", {{(NQ-1){1'b0}}, fb_tap}, {{(NQ-1){1'b0}}, fb_e});
        chk("R5 en at rise", {{(NQ-1){1'b0}}, bus_en}, {{(NQ-1){1'b0}}, en_e});
      end
    end
  end

  always @(negedge src) begin
    if (live && n >= 1) begin
      #1;
      chk_src(1'b0);
      chk("R5 en at fall", {{(NQ-1){1'b0}}, bus_en}, {{(NQ-1){1'b0}}, logic'(n % 2 == 0)});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic release_rst();
    @(negedge src);
    #1.5;
    n = 0;
    rst_n = 1'b1;
    live = 1;
  endtask

  task automatic hit_rst();
    @(negedge src);
    #1.5;
    live = 0;
    rst_n = 1'b0;
    #0.5;
    chk_reset();
  endtask

  initial begin
    #10;
    chk_reset();
    release_rst();
    repeat (100) @(posedge fast_clk);
    hit_rst();
    #5;
    run_en = 1'b0;                    // R7 bypass while held in reset
    #30;
    chk_reset();
    release_rst();
    repeat (20) @(posedge ref_clk);
    hit_rst();
    run_en = 1'b1;
    #10;
    release_rst();
    repeat (40) @(posedge fast_clk);
    #3;
    finish_run();
  end

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    finish_run();
  end
endmodule